// File: doc/BRIEF.md
# Error-Tagged Receive Queue with Automatic RTS Flow Control

This block buffers characters between a serial receiver and a CPU read port. Each stored entry is one data byte plus three error tags: parity error, framing error and break. The error tags stay with their byte, so the CPU sees the tags of the oldest character together with that character. With the queue mode bit set, up to `DEPTH` characters (16 by default) are held in arrival order. With the queue mode bit clear, which is the state after reset, the block holds only one character.

The block drives an active-low request-to-send handshake from its own fill level. When automatic flow control is enabled and the queue mode is on, RTS# goes high (deasserted) once the fill level reaches the selected trigger level. It stays high until the reader has emptied the buffer. A write that finds the buffer full is dropped and sets a sticky overrun flag, which a status read clears. An active-low ready output tells a DMA engine when data is waiting. A synchronous flush empties the buffer in one clock.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset `empty_o`=1, `ovr_o`=0, `rxrdy_n_o`=1, `rts_n_o`=0, and the read-port outputs are all zero.
- R2: In queue mode (`fifo_mode_i`=1) up to 16 entries are stored and read back in arrival order. `rd_data_o`, `rd_perr_o`, `rd_ferr_o` and `rd_brk_o` always show the oldest entry's byte and its own three tags.
- R3: With `fifo_mode_i`=0 the capacity is one entry.
- R4: A write that arrives while the buffer is at capacity is discarded, stored entries are unchanged, and `ovr_o` becomes 1 on the next cycle. This holds even if a read happens in the same cycle.
- R5: `ovr_o` stays 1 until a cycle with `stat_rd_i`=1, after which it is 0. If a new dropped write and `stat_rd_i` occur in the same cycle, `ovr_o` stays 1.
- R6: A read while the buffer is empty changes nothing. While empty, the read-port outputs are zero.
- R7: `fifo_clr_i`=1 empties the buffer by the next cycle. It wins over a read or write in the same cycle, and the write is dropped without setting the overrun flag. `ovr_o` and the trigger selection are unaffected.
- R8: `trig_sel_i` selects the trigger level: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14. With automatic flow control active, `rts_n_o` is 1 whenever the fill level is at or above the level.
- R9: Once high, `rts_n_o` stays 1 while the buffer holds any entry, even below the level. It returns to 0 in the cycle the fill level reaches zero.
- R10: Automatic flow control is active only when both `auto_rts_i`=1 and `fifo_mode_i`=1. Otherwise `rts_n_o`=0.
- R11: `empty_o` is 1 and `rxrdy_n_o` is 1 exactly when no entry is held. Otherwise both are 0.
- R12: A read and a write in the same cycle while below capacity both take effect, and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Receiver write strobe |
| wr_data_i | input | 8 | Received byte |
| wr_perr_i | input | 1 | Parity error tag of the byte |
| wr_ferr_i | input | 1 | Framing error tag of the byte |
| wr_brk_i | input | 1 | Break tag of the byte |
| rd_en_i | input | 1 | CPU read strobe, pops the oldest entry |
| stat_rd_i | input | 1 | Status read, clears the overrun flag |
| fifo_mode_i | input | 1 | 1: 16-entry queue, 0: single holding entry |
| fifo_clr_i | input | 1 | Synchronous flush |
| trig_sel_i | input | 2 | Trigger level select |
| auto_rts_i | input | 1 | Enable automatic RTS control |
| rd_data_o | output | 8 | Oldest byte |
| rd_perr_o | output | 1 | Parity tag of the oldest byte |
| rd_ferr_o | output | 1 | Framing tag of the oldest byte |
| rd_brk_o | output | 1 | Break tag of the oldest byte |
| empty_o | output | 1 | Buffer empty |
| ovr_o | output | 1 | Sticky overrun flag |
| rxrdy_n_o | output | 1 | Active-low data-ready for DMA |
| rts_n_o | output | 1 | Active-low request-to-send |

## Verification
The bench fills the queue to exactly 16 and pushes past it. A design that overwrote on full would return the wrong byte at the end of the drain, and one that counted past capacity would report data that was never stored. It walks RTS# through each trigger level, then drains down through the level and on to empty. A design without hysteresis would drop RTS# early, and one that waited for a read would hold it late. The bench also collides a flush with a write, a status read with a new overrun, and a read with a write when full. It toggles the mode bit with data present, which catches a single-entry mode that still accepts a second byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  // trigger level decode: 0->1, 1->4, 2->8, 3->14
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             clr_i,
  input  logic             wr_i,
  input  rx_entry_t        entry_i,
  input  logic             rd_i,
  output rx_entry_t        head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             drop_o
);
  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] count_q, count_d, cap;
  logic             full, empty, push, pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    ptr_inc = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    cap    = mode_i ? CNT_W'(DEPTH) : CNT_W'(1);
    full   = (count_q >= cap);
    empty  = (count_q == '0);
    push   = wr_i && !full && !clr_i;
    pop    = rd_i && !empty && !clr_i;
    drop_o = wr_i && full && !clr_i;
    if (clr_i) begin
      wptr_d  = '0;
      rptr_d  = '0;
      count_d = '0;
    end else begin
      wptr_d  = push ? ptr_inc(wptr_q) : wptr_q;
      rptr_d  = pop  ? ptr_inc(rptr_q) : rptr_q;
      count_d = count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wptr_q] <= entry_i;
  end

  assign head_o  = empty ? '0 : mem_q[rptr_q];
  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_i && !rd_i && !clr_i) |=> (count_q == $past(count_q))); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0)); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_i && !wr_i) |=> (count_q == '0)); // R6
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow
  import rxf_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             rts_n_o
);
  logic hold_q, rts_d, at_level;

  always_comb begin
    at_level = (32'(count_i) >= trig_level(sel_i));
    rts_d    = en_i && (at_level || (hold_q && count_i != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= rts_d;
  end

  assign rts_n_o = rts_d;

  AST_RTS_RISE_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n_o) |-> (32'(count_i) >= trig_level(sel_i))); // R8
endmodule

// File: rtl/rxf_ovr.sv
module rxf_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic ovr_o
);
  logic ovr_q, ovr_d;

  always_comb begin
    if (set_i)      ovr_d = 1'b1;
    else if (clr_i) ovr_d = 1'b0;
    else            ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign ovr_o = ovr_q;

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_i) |=> ovr_q); // R5
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_perr_i,
  input  logic              wr_ferr_i,
  input  logic              wr_brk_i,
  input  logic              rd_en_i,
  input  logic              stat_rd_i,
  input  logic              fifo_mode_i,
  input  logic              fifo_clr_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              auto_rts_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_brk_o,
  output logic              empty_o,
  output logic              ovr_o,
  output logic              rxrdy_n_o,
  output logic              rts_n_o
);
  rx_entry_t        wr_entry, head;
  logic [CNT_W-1:0] count;
  logic             drop;

  always_comb begin
    wr_entry.data = wr_data_i;
    wr_entry.perr = wr_perr_i;
    wr_entry.ferr = wr_ferr_i;
    wr_entry.brk  = wr_brk_i;
  end

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (fifo_mode_i),
    .clr_i   (fifo_clr_i),
    .wr_i    (wr_en_i),
    .entry_i (wr_entry),
    .rd_i    (rd_en_i),
    .head_o  (head),
    .count_o (count),
    .drop_o  (drop)
  );

  rxf_flow #(.CNT_W(CNT_W)) u_flow (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (auto_rts_i && fifo_mode_i),
    .sel_i   (trig_sel_i),
    .count_i (count),
    .rts_n_o (rts_n_o)
  );

  rxf_ovr u_ovr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (drop),
    .clr_i (stat_rd_i),
    .ovr_o (ovr_o)
  );

  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
  assign rd_brk_o  = head.brk;
  assign empty_o   = (count == '0);
  assign rxrdy_n_o = (count == '0);

  AST_RTS_OFF_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_rts_i && fifo_mode_i) |-> !rts_n_o); // R10
  AST_EMPTY_ZERO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (rd_data_o == '0 && !rd_perr_o && !rd_ferr_o && !rd_brk_o)); // R6
endmodule

// File: tb/rx_err_fifo_tb_top.sv
module rx_err_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, stat_rd, fmode, fclr, auto_rts;
  logic [7:0] wdata;
  logic [2:0] wflags;
  logic [1:0] tsel;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, empty, ovr, rxrdy_n, rts_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [10:0] q[$];
  bit          m_ovr  = 1'b0;
  bit          m_prev = 1'b0;

  always #4 clk = ~clk;

  rx_err_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata),
    .wr_perr_i(wflags[0]), .wr_ferr_i(wflags[1]), .wr_brk_i(wflags[2]),
    .rd_en_i(rd_en), .stat_rd_i(stat_rd), .fifo_mode_i(fmode),
    .fifo_clr_i(fclr), .trig_sel_i(tsel), .auto_rts_i(auto_rts),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr),
    .rd_brk_o(rd_brk), .empty_o(empty), .ovr_o(ovr), .rxrdy_n_o(rxrdy_n),
    .rts_n_o(rts_n)
  );

  function automatic int lvl(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic bit exp_rts();
    bit en = auto_rts && fmode;
    return en && (q.size() >= lvl(tsel) || (m_prev && q.size() != 0));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [10:0] h = (q.size() != 0) ? q[0] : 11'h0;
    chk("R2", "rd_data", rd_data, h[7:0]);
    chk("R2", "tags", {rd_brk, rd_ferr, rd_perr}, h[10:8]);
    chk("R11", "empty", empty, q.size() == 0);
    chk("R11", "rxrdy_n", rxrdy_n, q.size() == 0);
    chk("R5", "ovr", ovr, m_ovr);
    chk("R8/R9", "rts_n", rts_n, exp_rts());
  endtask

  task automatic model_edge();
    int cap = fmode ? 16 : 1;
    bit full = q.size() >= cap;
    m_prev = exp_rts();
    if (fclr) q.delete();
    else begin
      if (rd_en && q.size() != 0) void'(q.pop_front());
      if (wr_en && !full) q.push_back({wflags, wdata});
    end
    if (wr_en && !fclr && full) m_ovr = 1'b1;
    else if (stat_rd) m_ovr = 1'b0;
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] f,
                     input bit r, input bit c, input bit s);
    wr_en = w; wdata = d; wflags = f; rd_en = r; fclr = c; stat_rd = s;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); cyc(0, 8'h0, 3'b0, 0, 0, 0); endtask
  task automatic put(input logic [7:0] d, input logic [2:0] f); cyc(1, d, f, 0, 0, 0); endtask
  task automatic get(); cyc(0, 8'h0, 3'b0, 1, 0, 0); endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<20000", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; stat_rd = 0; fmode = 0; fclr = 0;
    auto_rts = 0; tsel = 2'd0; wdata = 0; wflags = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "empty", empty, 1); chk("R1", "ovr", ovr, 0);
    chk("R1", "rxrdy_n", rxrdy_n, 1); chk("R1", "rts_n", rts_n, 0);
    chk("R1", "rd_data", rd_data, 0);

    // R3: single-entry mode, second write dropped (R4), status read (R5)
    put(8'hA1, 3'b001); put(8'hA2, 3'b010); idle();
    cyc(0, 0, 0, 0, 0, 1); get(); get(); // R6 read when empty
    // R10: auto on but not queue mode
    auto_rts = 1; put(8'h11, 3'b0); get();

    // R2/R8: queue mode, level 14, fill to 16, overrun beyond
    fmode = 1; tsel = 2'd3;
    for (int i = 0; i < 16; i++) put(8'h30 + 8'(i), 3'(i));
    put(8'hEE, 3'b111);                 // R4 dropped
    cyc(1, 8'hEF, 3'b111, 1, 0, 1);     // R4/R5 full+read+write: drop, set wins
    cyc(0, 0, 0, 0, 0, 1);              // R5 clear
    for (int i = 0; i < 16; i++) get(); // R9 hysteresis down to empty
    get();                              // R6

    // R8 each level, R9 hysteresis, R12 simultaneous
    for (int s = 0; s < 4; s++) begin
      tsel = 2'(s);
      for (int i = 0; i < 9; i++) put(8'(s * 16 + i), 3'(s + i));
      cyc(1, 8'h77, 3'b101, 1, 0, 0); // R12
      for (int i = 0; i < 10; i++) get();
    end

    // R7: flush with concurrent write, overrun preserved
    tsel = 2'd1;
    for (int i = 0; i < 17; i++) put(8'h50 + 8'(i), 3'b011);
    cyc(1, 8'h99, 3'b111, 1, 1, 0); idle();
    cyc(1, 8'h98, 3'b000, 0, 0, 0); cyc(0, 0, 0, 0, 1, 1); idle();

    // R10: auto off while above level; mode drop with data (R3)
    for (int i = 0; i < 6; i++) put(8'hC0 + 8'(i), 3'b100);
    auto_rts = 0; idle(); auto_rts = 1; idle();
    fmode = 0; put(8'hDD, 3'b0); get(); fmode = 1; idle();
    for (int i = 0; i < 6; i++) get();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule